// File: doc/BRIEF.md
# Serial Port Interrupt Controller

This block collects the interrupt causes of a serial transceiver and turns them into one prioritised interrupt request for a CPU. It handles three causes: a finished transmit word, a finished receive word, and a receive error. The receive error is the OR of three single-cycle error pulses: overrun, framing and parity. Each cause latches into its own sticky status flag. Each cause also has an enable bit, and the enable gates only the request. Software reaches the flags, the enables and a shared 2-bit port priority through a small synchronous register port.

The request goes to the CPU only when an enabled flag is pending and the port priority is strictly above the CPU's current 2-bit mask level. Next to the request the block presents a fixed vector address for the enabled pending cause of highest rank. The ranking is error first, then receive, then transmit. Both outputs are registered.

Top module: `sio_irq_ctrl`

## Requirements
- R1: In the cycle after reset is released, `irq_req`, `irq_vector` and `reg_rdata` are 0, and all flags, enables and the priority read back as 0.
- R2: A status flag is sticky. Its event sets it whatever its enable holds, and it stays set until software clears it. Status register (address 0) bits: bit0 transmit done, bit1 receive done, bit2 error.
- R3: A pulse on any one of `ev_overrun`, `ev_framing` or `ev_parity` sets the error flag (status bit2).
- R4: A write to address 0 clears every flag whose bit in `reg_wdata` is 1. Flags whose bit is 0 are left unchanged.
- R5: If a cause's event pulse and a write-1 clear of its flag fall in the same cycle, the flag ends up set.
- R6: Address 1 holds the enables in bits [2:0], in the same bit order as the status register. Address 2 holds the priority in bits [1:0]. Address 3 reads 0 and ignores writes. `reg_rdata` shows the addressed register one cycle after `reg_addr` is presented. If a write lands in that same cycle, the value shown is the one from before the write.
- R7: `irq_req` is 1 in a cycle exactly when, one cycle earlier, some flag was set with its enable at 1 and the priority was strictly greater than `cpu_mask`.
- R8: A priority of 0 keeps `irq_req` at 0, whatever the flags and enables hold.
- R9: With the same one-cycle lag, `irq_vector` is 0x000028 when the error cause is enabled and pending. Otherwise it is 0x00002A when receive is enabled and pending. Otherwise it is 0x00002C when transmit is enabled and pending. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_tx_done | input | 1 | Pulse: transmit word finished |
| ev_rx_done | input | 1 | Pulse: receive word finished |
| ev_overrun | input | 1 | Pulse: receive overrun |
| ev_framing | input | 1 | Pulse: framing error |
| ev_parity | input | 1 | Pulse: parity error |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| cpu_mask | input | 2 | CPU current interrupt mask level |
| irq_req | output | 1 | Registered interrupt request |
| irq_vector | output | 24 | Registered vector address |

## Verification
Events are first pulsed with every enable off, so that flag latching can be told apart from request gating. Clear writes are then sent with zero bits and with one bits, and one clear meets an event in the same cycle. Each error input is pulsed on its own, which shows that each of the three reaches the shared flag. With enables on, the priority is swept against a mask set equal, below and above. Causes are then raised one after another so that the vector order shows. A behavioural model is compared with the request, the vector and the read data on every clock.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;
  localparam int NUM_SRC = 3;
  localparam int SRC_TX  = 0;
  localparam int SRC_RX  = 1;
  localparam int SRC_ERR = 2;
  localparam int ADDR_W  = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_STAT = 2'd0,
    REG_EN   = 2'd1,
    REG_PRIO = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/sio_irq_flag.sv
module sio_irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // set takes precedence over a same-cycle clear
  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/sio_irq_regs.sv
module sio_irq_regs
  import sio_irq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PRIO_W = 2,
  parameter int NSRC   = NUM_SRC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NSRC-1:0]   flags_i,
  output logic [NSRC-1:0]   en_o,
  output logic [PRIO_W-1:0] prio_o,
  output logic [NSRC-1:0]   clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int PAD_SRC  = DATA_W - NSRC;
  localparam int PAD_PRIO = DATA_W - PRIO_W;

  reg_sel_e sel;
  logic [DATA_W-1:0] rd_mux;
  logic unused_wbits;

  assign sel = reg_sel_e'(addr_i);
  assign unused_wbits = ^wdata_i[DATA_W-1:NSRC];
  assign clr_o = (wr_i && sel == REG_STAT) ? wdata_i[NSRC-1:0] : '0;

  always_comb begin
    case (sel)
      REG_STAT: rd_mux = {{PAD_SRC{1'b0}}, flags_i};
      REG_EN:   rd_mux = {{PAD_SRC{1'b0}}, en_o};
      REG_PRIO: rd_mux = {{PAD_PRIO{1'b0}}, prio_o};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_o    <= '0;
      prio_o  <= '0;
      rdata_o <= '0;
    end else begin
      rdata_o <= rd_mux;
      if (wr_i && sel == REG_EN)   en_o   <= wdata_i[NSRC-1:0];
      if (wr_i && sel == REG_PRIO) prio_o <= wdata_i[PRIO_W-1:0];
    end
  end
endmodule

// File: rtl/sio_irq_arb.sv
module sio_irq_arb #(
  parameter int                     NSRC     = 3,
  parameter int                     PRIO_W   = 2,
  parameter int                     VEC_W    = 24,
  parameter logic [VEC_W-1:0]       VEC_BASE = 24'h000028,
  parameter int                     VEC_STEP = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   flags_i,
  input  logic [NSRC-1:0]   en_i,
  input  logic [PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0] mask_i,
  output logic              irq_o,
  output logic [VEC_W-1:0]  vec_o
);
  logic [NSRC-1:0]  pend;
  logic [VEC_W-1:0] vec_n;
  logic             irq_n;

  assign pend  = flags_i & en_i;
  assign irq_n = (|pend) && (prio_i > mask_i);

  // higher source index outranks lower; vector falls as rank rises
  always_comb begin
    vec_n = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (pend[i]) vec_n = VEC_W'(VEC_BASE + VEC_W'(VEC_STEP * (NSRC - 1 - i)));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
      vec_o <= '0;
    end else begin
      irq_o <= irq_n;
      vec_o <= vec_n;
    end
  end
endmodule

// File: rtl/sio_irq_ctrl.sv
module sio_irq_ctrl
  import sio_irq_pkg::*;
#(
  parameter int               DATA_W   = 8,
  parameter int               PRIO_W   = 2,
  parameter int               VEC_W    = 24,
  parameter logic [VEC_W-1:0] VEC_BASE = 24'h000028,
  parameter int               VEC_STEP = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_tx_done,
  input  logic              ev_rx_done,
  input  logic              ev_overrun,
  input  logic              ev_framing,
  input  logic              ev_parity,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [PRIO_W-1:0] cpu_mask,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vector
);
  logic [NUM_SRC-1:0] set_vec;
  logic [NUM_SRC-1:0] clr_vec;
  logic [NUM_SRC-1:0] flags_q;
  logic [NUM_SRC-1:0] en_q;
  logic [PRIO_W-1:0]  prio_q;

  assign set_vec[SRC_TX]  = ev_tx_done;
  assign set_vec[SRC_RX]  = ev_rx_done;
  assign set_vec[SRC_ERR] = ev_overrun | ev_framing | ev_parity;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
    sio_irq_flag flag_i (
      .clk    (clk),
      .rst    (rst),
      .set_i  (set_vec[g]),
      .clr_i  (clr_vec[g]),
      .flag_o (flags_q[g])
    );
  end

  sio_irq_regs #(
    .DATA_W (DATA_W),
    .PRIO_W (PRIO_W),
    .NSRC   (NUM_SRC)
  ) regs_i (
    .clk     (clk),
    .rst     (rst),
    .wr_i    (reg_wr),
    .addr_i  (reg_addr),
    .wdata_i (reg_wdata),
    .flags_i (flags_q),
    .en_o    (en_q),
    .prio_o  (prio_q),
    .clr_o   (clr_vec),
    .rdata_o (reg_rdata)
  );

  sio_irq_arb #(
    .NSRC     (NUM_SRC),
    .PRIO_W   (PRIO_W),
    .VEC_W    (VEC_W),
    .VEC_BASE (VEC_BASE),
    .VEC_STEP (VEC_STEP)
  ) arb_i (
    .clk     (clk),
    .rst     (rst),
    .flags_i (flags_q),
    .en_i    (en_q),
    .prio_i  (prio_q),
    .mask_i  (cpu_mask),
    .irq_o   (irq_req),
    .vec_o   (irq_vector)
  );
endmodule

// File: rtl/sio_irq_ctrl_chk.sv
module sio_irq_ctrl_chk #(
  parameter int DATA_W = 8,
  parameter int PRIO_W = 2,
  parameter int VEC_W  = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              ev_tx_done,
  input logic              ev_rx_done,
  input logic              ev_overrun,
  input logic              ev_framing,
  input logic              ev_parity,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [PRIO_W-1:0] cpu_mask,
  input logic              irq_req,
  input logic [VEC_W-1:0]  irq_vector,
  input logic [2:0]        flags,
  input logic [2:0]        enables,
  input logic [PRIO_W-1:0] prio
);
  logic [2:0] evs;
  logic [2:0] wclr;
  assign evs  = {ev_overrun | ev_framing | ev_parity, ev_rx_done, ev_tx_done};
  assign wclr = (reg_wr && reg_addr == 2'd0) ? reg_wdata[2:0] : 3'b000;

  // R2 R5: any event leaves its flag set next cycle
  a_r5_event_sets: assert property (@(posedge clk) disable iff (rst)
    (evs != 3'b000) |=> ((flags & $past(evs)) == $past(evs)));

  // R2: a set flag with no clear stays set
  a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
    (flags != 3'b000) |=> ((flags & $past(flags & ~wclr)) == $past(flags & ~wclr)));

  // R4: a write-1 clear without a competing event empties the flag
  a_r4_w1c: assert property (@(posedge clk) disable iff (rst)
    (wclr != 3'b000) |=> ((flags & $past(wclr & ~evs)) == 3'b000));

  // R7: a request needs priority strictly above mask and an enabled flag
  a_r7_gate: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> ($past(prio > cpu_mask) && ($past(flags & enables) != 3'b000)));

  // R8: priority zero blocks requests
  a_r8_prio_zero: assert property (@(posedge clk) disable iff (rst)
    (prio == '0) |=> !irq_req);

  // R9: a raised request always carries one of the three vectors
  a_r9_vector_set: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_vector == 24'h28 || irq_vector == 24'h2A || irq_vector == 24'h2C));
endmodule

bind sio_irq_ctrl sio_irq_ctrl_chk #(
  .DATA_W (DATA_W),
  .PRIO_W (PRIO_W),
  .VEC_W  (VEC_W)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .ev_tx_done (ev_tx_done),
  .ev_rx_done (ev_rx_done),
  .ev_overrun (ev_overrun),
  .ev_framing (ev_framing),
  .ev_parity  (ev_parity),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .cpu_mask   (cpu_mask),
  .irq_req    (irq_req),
  .irq_vector (irq_vector),
  .flags      (flags_q),
  .enables    (en_q),
  .prio       (prio_q)
);

// File: tb/sio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module sio_irq_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_tx = 0, ev_rx = 0, ev_ov = 0, ev_fr = 0, ev_pa = 0;
  logic reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic [1:0] cpu_mask = 0;
  logic irq_req;
  logic [23:0] irq_vector;

  int n_checks = 0;
  int n_errors = 0;

  always #4 clk = ~clk;

  sio_irq_ctrl dut_i (
    .clk(clk), .rst(rst),
    .ev_tx_done(ev_tx), .ev_rx_done(ev_rx),
    .ev_overrun(ev_ov), .ev_framing(ev_fr), .ev_parity(ev_pa),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cpu_mask(cpu_mask),
    .irq_req(irq_req), .irq_vector(irq_vector)
  );

  // behavioural reference
  int m_flags = 0, m_en = 0, m_prio = 0;
  int m_rdata = 0, m_irq = 0, m_vec = 0;

  always @(posedge clk) begin
    int pend, clr, evv;
    if (rst) begin
      m_flags = 0; m_en = 0; m_prio = 0;
      m_rdata = 0; m_irq = 0; m_vec = 0;
    end else begin
      case (reg_addr)
        2'd0: m_rdata = m_flags;
        2'd1: m_rdata = m_en;
        2'd2: m_rdata = m_prio;
        default: m_rdata = 0;
      endcase
      pend  = m_flags & m_en;
      m_irq = (pend != 0 && m_prio > int'(cpu_mask)) ? 1 : 0;
      if (pend & 4) m_vec = 'h28;
      else if (pend & 2) m_vec = 'h2A;
      else if (pend & 1) m_vec = 'h2C;
      else m_vec = 0;
      clr = (reg_wr && reg_addr == 2'd0) ? int'(reg_wdata & 8'h07) : 0;
      evv = ((ev_ov | ev_fr | ev_pa) ? 4 : 0) | (ev_rx ? 2 : 0) | (ev_tx ? 1 : 0);
      m_flags = evv | (m_flags & ~clr & 7);
      if (reg_wr && reg_addr == 2'd1) m_en = int'(reg_wdata & 8'h07);
      if (reg_wr && reg_addr == 2'd2) m_prio = int'(reg_wdata & 8'h03);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R7 irq_req model", int'(irq_req), m_irq);
      chk("R9 irq_vector model", int'(irq_vector), m_vec);
      chk("R6 reg_rdata model", int'(reg_rdata), m_rdata);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input int exp, input string tag);
    reg_addr = a;
    @(negedge clk);
    chk(tag, int'(reg_rdata), exp);
  endtask

  task automatic pulse(input int which);
    case (which)
      0: ev_tx = 1;
      1: ev_rx = 1;
      2: ev_ov = 1;
      3: ev_fr = 1;
      default: ev_pa = 1;
    endcase
    @(negedge clk);
    ev_tx = 0; ev_rx = 0; ev_ov = 0; ev_fr = 0; ev_pa = 0;
  endtask

  initial begin
    #1600000;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    tick(3);
    rst = 0;
    tick(1);
    // R1 reset state
    chk("R1 irq_req", int'(irq_req), 0);
    chk("R1 irq_vector", int'(irq_vector), 0);
    chk("R1 reg_rdata", int'(reg_rdata), 0);
    rd_chk(2'd0, 0, "R1 status");
    rd_chk(2'd1, 0, "R1 enable");
    rd_chk(2'd2, 0, "R1 priority");

    // R2: flag latches with enable off
    wr(2'd2, 8'd3);
    pulse(0);
    rd_chk(2'd0, 1, "R2 tx flag with enable off");
    chk("R2 no request while disabled", int'(irq_req), 0);
    tick(3);
    rd_chk(2'd0, 1, "R2 flag stays set");

    // R4: zero write leaves it, one write clears
    wr(2'd0, 8'h00);
    rd_chk(2'd0, 1, "R4 write zero no effect");
    wr(2'd0, 8'h01);
    rd_chk(2'd0, 0, "R4 write one clears");

    // R3: each error input reaches bit2
    for (int k = 2; k < 5; k++) begin
      pulse(k);
      rd_chk(2'd0, 4, "R3 error flag");
      wr(2'd0, 8'h04);
      rd_chk(2'd0, 0, "R3 error cleared");
    end

    // R5: event beats clear in same cycle
    ev_rx = 1; reg_wr = 1; reg_addr = 2'd0; reg_wdata = 8'h02;
    @(negedge clk);
    ev_rx = 0; reg_wr = 0;
    rd_chk(2'd0, 2, "R5 event wins over clear");
    wr(2'd0, 8'h07);
    rd_chk(2'd0, 0, "R5 cleared afterwards");

    // R6: enable and priority registers, read during write, spare address
    wr(2'd1, 8'hFF);
    rd_chk(2'd1, 7, "R6 enable readback");
    wr(2'd2, 8'h02);
    rd_chk(2'd2, 2, "R6 priority readback");
    wr(2'd2, 8'h03);
    chk("R6 read during write shows old", int'(reg_rdata), 2);
    rd_chk(2'd2, 3, "R6 new priority");
    wr(2'd3, 8'hFF);
    rd_chk(2'd3, 0, "R6 spare address reads zero");
    wr(2'd2, 8'h02);

    // R7: strict priority above mask
    cpu_mask = 2'd1;
    pulse(0);
    tick(1);
    chk("R7 request prio>mask", int'(irq_req), 1);
    chk("R9 tx vector", int'(irq_vector), 'h2C);
    cpu_mask = 2'd2;
    tick(2);
    chk("R7 no request prio==mask", int'(irq_req), 0);
    cpu_mask = 2'd3;
    tick(2);
    chk("R7 no request prio<mask", int'(irq_req), 0);
    cpu_mask = 2'd1;

    // R9: ordering
    pulse(1);
    tick(1);
    chk("R9 rx outranks tx", int'(irq_vector), 'h2A);
    pulse(4);
    tick(1);
    chk("R9 error outranks rx", int'(irq_vector), 'h28);
    wr(2'd1, 8'h03);
    tick(1);
    chk("R9 error disabled falls to rx", int'(irq_vector), 'h2A);
    wr(2'd0, 8'h02);
    tick(1);
    chk("R9 rx cleared falls to tx", int'(irq_vector), 'h2C);

    // R8: priority zero masks everything
    wr(2'd1, 8'h07);
    cpu_mask = 2'd0;
    wr(2'd2, 8'h00);
    tick(2);
    chk("R8 prio zero no request", int'(irq_req), 0);
    wr(2'd2, 8'h01);
    tick(1);
    chk("R7 prio one over mask zero", int'(irq_req), 1);
    wr(2'd1, 8'h00);
    tick(1);
    chk("R7 enables off drop request", int'(irq_req), 0);
    chk("R9 no enabled pending vector", int'(irq_vector), 0);

    tick(4);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule